// File: doc/BRIEF.md
# USB OUT Transfer Receive Controller

This block sits behind the packet decoder of a bulk, control or interrupt OUT endpoint. It receives the data packets that the host sends and stores their bytes in a receive FIFO that keeps packet boundaries. Every stored entry carries a byte-valid bit and a packet-end tag, so that software reading the FIFO can tell where each packet stops. For every packet it stores, the block returns an ACK. It also sets a sticky per-packet interrupt flag.

A transfer ends when a packet arrives that is shorter than the configured maximum packet size. A packet of zero bytes also ends a transfer. At that point the block sets a sticky end-of-transfer flag. While that flag is set, every further packet is answered with NAK and its data is dropped, so software can drain the transfer before the next one begins.

A packet whose CRC is bad, or that runs past the maximum size, is removed from the FIFO again. It gets no handshake, so the host retries it. A packet is also answered with NAK when the FIFO cannot hold a full maximum-size packet at the moment the packet starts.

Top module: `usb_out_rx_ctrl`

## Requirements
- R1: After reset both interrupt flags are low, the FIFO is empty and no handshake is issued.
- R2: The bytes of an accepted packet appear at the read port in arrival order with byte-valid 1. Only the last byte carries packet-end 1.
- R3: The read port shows the oldest stored entry whenever rd_empty is low. Pulsing rd_en for one cycle advances to the next entry.
- R4: For an accepted packet with good CRC, hs_valid pulses with hs_nak 0 in the cycle after pkt_end, and irq_eof rises in that same cycle. Both outputs are registered on the same edge.
- R5: irq_eot sets when an accepted packet has fewer bytes than max_pkt_size. A packet of exactly max_pkt_size bytes leaves irq_eot unchanged.
- R6: A zero-byte packet stores exactly one entry with packet-end 1, byte-valid 0 and data 0, sets irq_eot and is acknowledged.
- R7: While irq_eot is set, a packet with good CRC is answered with hs_nak 1. It stores nothing and changes no flag.
- R8: A clr_eot pulse makes irq_eot low in the next cycle, and the next packet is accepted normally.
- R9: A packet with bad CRC leaves no visible entry, sets no flag and gets no handshake. The next packet is stored in its place.
- R10: If the FIFO free space is below max_pkt_size when pkt_start arrives, that packet gets hs_nak 1 and stores nothing.
- R11: A packet carrying more bytes than max_pkt_size is removed like a bad-CRC packet and gets no handshake.
- R12: A clr_eof pulse clears irq_eof. If a packet completes in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Pulse marking the start of an OUT data packet |
| pkt_valid | input | 1 | A packet byte is present on pkt_data |
| pkt_data | input | 8 | Packet byte |
| pkt_end | input | 1 | Pulse after the last byte of a packet, in a cycle without a byte |
| pkt_crc_ok | input | 1 | CRC result, qualified by pkt_end |
| max_pkt_size | input | MPS_W | Endpoint maximum packet size in bytes (at least 1) |
| clr_eof | input | 1 | Clear strobe for irq_eof |
| clr_eot | input | 1 | Clear strobe for irq_eot |
| rd_en | input | 1 | Pop the current FIFO entry |
| rd_data | output | 8 | Data of the current FIFO entry |
| rd_eof | output | 1 | Current entry is the last of a packet |
| rd_bv | output | 1 | Current entry holds a real byte |
| rd_empty | output | 1 | No complete entry is available for reading |
| hs_valid | output | 1 | One-cycle handshake pulse |
| hs_nak | output | 1 | Handshake is NAK (1) or ACK (0) |
| irq_eof | output | 1 | Sticky packet-end interrupt flag |
| irq_eot | output | 1 | Sticky end-of-transfer interrupt flag |

## Verification
Errors in the write pointer or the commit pointer show up at the read port in the cycle after the packet ends. A corrupted packet then leaks into the FIFO, the tagging is wrong, or good packets disappear. A stuck end-of-transfer flag shows as a NAK on the very next packet. A flag that was never set shows as an ACK where the bench expects a NAK. A wrong free-space check is visible only when the FIFO is nearly full, so the bench fills it to the last entry before it sends one more packet.

// File: rtl/usbrx_pkg.sv
`timescale 1ns/1ps
package usbrx_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              eof;
        logic              bv;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_RECV = 2'd1,
        RX_DROP = 2'd2
    } rx_state_e;

    function automatic rx_entry_t mk_entry(input logic eof, input logic bv,
                                           input logic [BYTE_W-1:0] data);
        rx_entry_t e;
        e.eof  = eof;
        e.bv   = bv;
        e.data = data;
        return e;
    endfunction

endpackage

// File: rtl/usbrx_fifo.sv
`timescale 1ns/1ps
module usbrx_fifo
    import usbrx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  rx_entry_t                wdata,
    input  logic                     commit,
    input  logic                     rollback,
    input  logic                     rd_en,
    output rx_entry_t                rd_entry,
    output logic                     rd_empty,
    output logic [$clog2(DEPTH):0]   free_cnt
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    rx_entry_t       mem [DEPTH];
    logic [PW-1:0]   wr_ptr, cm_ptr, rd_ptr;
    logic [PW-1:0]   wr_ptr_nxt;
    logic [PW-1:0]   wr_level;

    assign wr_ptr_nxt = wr_ptr + (we ? PW'(1) : PW'(0));
    assign wr_level   = wr_ptr - rd_ptr;
    assign free_cnt   = PW'(DEPTH) - wr_level;
    assign rd_empty   = (cm_ptr == rd_ptr);
    assign rd_entry   = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (rollback) wr_ptr <= cm_ptr;
            else          wr_ptr <= wr_ptr_nxt;
            if (commit)   cm_ptr <= wr_ptr_nxt;
            if (rd_en && !rd_empty) rd_ptr <= rd_ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (we && !rollback) mem[wr_ptr[AW-1:0]] <= wdata;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        we |-> (wr_level < PW'(DEPTH)))
        else $error("fifo write while full"); // R10

    AST_ROLLBACK_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (rollback && !commit) |=> (wr_ptr == cm_ptr))
        else $error("rollback did not restore write pointer"); // R9

    AST_COMMIT_BEHIND_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cm_ptr - rd_ptr) <= wr_level)
        else $error("commit pointer ahead of write pointer"); // R3
endmodule

// File: rtl/usbrx_pkt_rx.sv
`timescale 1ns/1ps
module usbrx_pkt_rx
    import usbrx_pkg::*;
#(
    parameter int MPS_W = 11,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pkt_start,
    input  logic                     pkt_valid,
    input  logic [BYTE_W-1:0]        pkt_data,
    input  logic                     pkt_end,
    input  logic                     pkt_crc_ok,
    input  logic [MPS_W-1:0]         max_pkt_size,
    input  logic                     eot_pending,
    input  logic [$clog2(DEPTH):0]   free_cnt,
    output logic                     we,
    output rx_entry_t                wdata,
    output logic                     commit,
    output logic                     rollback,
    output logic                     frame_short,
    output logic                     hs_valid,
    output logic                     hs_nak
);
    rx_state_e           state;
    logic [MPS_W:0]      cnt;
    logic [MPS_W:0]      mps_ext;
    logic                pend_vld;
    logic [BYTE_W-1:0]   pend_data;
    logic                oversize;
    logic                room_ok;
    logic                at_limit;
    logic                good_end;

    assign mps_ext     = {1'b0, max_pkt_size};
    assign room_ok     = (free_cnt != '0) && (32'(free_cnt) >= 32'(max_pkt_size));
    assign at_limit    = (cnt >= mps_ext);
    assign good_end    = pkt_crc_ok && !oversize;
    assign frame_short = (cnt < mps_ext);

    always_comb begin
        we       = 1'b0;
        wdata    = mk_entry(1'b0, 1'b0, '0);
        commit   = 1'b0;
        rollback = 1'b0;
        if (state == RX_RECV) begin
            if (pkt_valid && !at_limit && pend_vld) begin
                we    = 1'b1;
                wdata = mk_entry(1'b0, 1'b1, pend_data);
            end
            if (pkt_end) begin
                if (good_end) begin
                    we     = 1'b1;
                    wdata  = pend_vld ? mk_entry(1'b1, 1'b1, pend_data)
                                      : mk_entry(1'b1, 1'b0, '0);
                    commit = 1'b1;
                end else begin
                    rollback = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            pend_vld  <= 1'b0;
            pend_data <= '0;
            oversize  <= 1'b0;
            hs_valid  <= 1'b0;
            hs_nak    <= 1'b0;
        end else begin
            hs_valid <= 1'b0;
            hs_nak   <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (pkt_start) begin
                        state    <= (!eot_pending && room_ok) ? RX_RECV : RX_DROP;
                        cnt      <= '0;
                        pend_vld <= 1'b0;
                        oversize <= 1'b0;
                    end
                end
                RX_RECV: begin
                    if (pkt_valid) begin
                        if (at_limit) begin
                            oversize <= 1'b1;
                        end else begin
                            cnt       <= cnt + 1'b1;
                            pend_data <= pkt_data;
                            pend_vld  <= 1'b1;
                        end
                    end
                    if (pkt_end) begin
                        state    <= RX_IDLE;
                        hs_valid <= good_end;
                    end
                end
                RX_DROP: begin
                    if (pkt_end) begin
                        state    <= RX_IDLE;
                        hs_valid <= pkt_crc_ok;
                        hs_nak   <= pkt_crc_ok;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    AST_NAK_WHILE_EOT: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && pkt_start && eot_pending) |=> (state == RX_DROP))
        else $error("packet accepted while end-of-transfer pending"); // R7

    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == RX_DROP) |-> !we)
        else $error("write while dropping a packet"); // R7

    AST_NO_FULL_ROOM_NAK: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && pkt_start && !room_ok) |=> (state == RX_DROP))
        else $error("packet accepted without room"); // R10

    AST_OVERSIZE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (state == RX_RECV && pkt_end && oversize) |=> !hs_valid)
        else $error("oversize packet acknowledged"); // R11
endmodule

// File: rtl/usbrx_irq.sv
`timescale 1ns/1ps
module usbrx_irq (
    input  logic clk,
    input  logic rst,
    input  logic frame_done,
    input  logic frame_short,
    input  logic clr_eof,
    input  logic clr_eot,
    output logic eof_flag,
    output logic eot_flag
);
    logic set_eot;

    assign set_eot = frame_done && frame_short;

    always_ff @(posedge clk) begin
        if (rst) begin
            eof_flag <= 1'b0;
            eot_flag <= 1'b0;
        end else begin
            if (frame_done)   eof_flag <= 1'b1;
            else if (clr_eof) eof_flag <= 1'b0;
            if (set_eot)      eot_flag <= 1'b1;
            else if (clr_eot) eot_flag <= 1'b0;
        end
    end

    AST_EOT_WITH_EOF: assert property (@(posedge clk) disable iff (rst)
        $rose(eot_flag) |-> eof_flag)
        else $error("end-of-transfer without end-of-frame"); // R5

    AST_CLR_EOT: assert property (@(posedge clk) disable iff (rst)
        (clr_eot && !set_eot) |=> !eot_flag)
        else $error("end-of-transfer flag not cleared"); // R8

    AST_EOF_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> eof_flag)
        else $error("end-of-frame flag lost"); // R12
endmodule

// File: rtl/usb_out_rx_ctrl.sv
`timescale 1ns/1ps
module usb_out_rx_ctrl
    import usbrx_pkg::*;
#(
    parameter int MPS_W      = 11,
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_start,
    input  logic              pkt_valid,
    input  logic [7:0]        pkt_data,
    input  logic              pkt_end,
    input  logic              pkt_crc_ok,
    input  logic [MPS_W-1:0]  max_pkt_size,
    input  logic              clr_eof,
    input  logic              clr_eot,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              rd_eof,
    output logic              rd_bv,
    output logic              rd_empty,
    output logic              hs_valid,
    output logic              hs_nak,
    output logic              irq_eof,
    output logic              irq_eot
);
    localparam int PW = $clog2(FIFO_DEPTH) + 1;

    logic            we, commit, rollback, frame_short;
    rx_entry_t       wdata, rd_entry;
    logic [PW-1:0]   free_cnt;

    usbrx_pkt_rx #(.MPS_W(MPS_W), .DEPTH(FIFO_DEPTH)) pkt_i (
        .clk          (clk),
        .rst          (rst),
        .pkt_start    (pkt_start),
        .pkt_valid    (pkt_valid),
        .pkt_data     (pkt_data),
        .pkt_end      (pkt_end),
        .pkt_crc_ok   (pkt_crc_ok),
        .max_pkt_size (max_pkt_size),
        .eot_pending  (irq_eot),
        .free_cnt     (free_cnt),
        .we           (we),
        .wdata        (wdata),
        .commit       (commit),
        .rollback     (rollback),
        .frame_short  (frame_short),
        .hs_valid     (hs_valid),
        .hs_nak       (hs_nak)
    );

    usbrx_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .wdata    (wdata),
        .commit   (commit),
        .rollback (rollback),
        .rd_en    (rd_en),
        .rd_entry (rd_entry),
        .rd_empty (rd_empty),
        .free_cnt (free_cnt)
    );

    usbrx_irq irq_i (
        .clk         (clk),
        .rst         (rst),
        .frame_done  (commit),
        .frame_short (frame_short),
        .clr_eof     (clr_eof),
        .clr_eot     (clr_eot),
        .eof_flag    (irq_eof),
        .eot_flag    (irq_eot)
    );

    assign rd_data = rd_entry.data;
    assign rd_eof  = rd_entry.eof;
    assign rd_bv   = rd_entry.bv;

    AST_HS_PULSE: assert property (@(posedge clk) disable iff (rst)
        hs_valid |=> !hs_valid)
        else $error("handshake longer than one cycle"); // R4

    AST_ACK_SETS_EOF: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && !hs_nak) |-> irq_eof)
        else $error("ACK without end-of-frame flag"); // R4
endmodule

// File: tb/usb_out_rx_ctrl_tb.sv
`timescale 1ns/1ps
module usb_out_rx_ctrl_tb_top;
    localparam int MPS_W = 7;
    localparam int DEPTH = 16;
    localparam int MPS   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pkt_start = 0, pkt_valid = 0, pkt_end = 0, pkt_crc_ok = 0;
    logic [7:0] pkt_data = '0;
    logic [MPS_W-1:0] max_pkt_size = MPS_W'(MPS);
    logic clr_eof = 0, clr_eot = 0, rd_en = 0;
    logic [7:0] rd_data;
    logic rd_eof, rd_bv, rd_empty, hs_valid, hs_nak, irq_eof, irq_eot;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    usb_out_rx_ctrl #(.MPS_W(MPS_W), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_valid(pkt_valid),
        .pkt_data(pkt_data), .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok),
        .max_pkt_size(max_pkt_size), .clr_eof(clr_eof), .clr_eot(clr_eot),
        .rd_en(rd_en), .rd_data(rd_data), .rd_eof(rd_eof), .rd_bv(rd_bv),
        .rd_empty(rd_empty), .hs_valid(hs_valid), .hs_nak(hs_nak),
        .irq_eof(irq_eof), .irq_eot(irq_eot)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // Sends a packet of n bytes base, base+1, ...; returns at the negedge after the end edge.
    task automatic send_pkt(input int n, input int base, input bit crc, input bit clr_at_end);
        @(negedge clk) pkt_start = 1'b1;
        @(negedge clk) pkt_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            pkt_valid = 1'b1;
            pkt_data  = 8'(base + i);
            @(negedge clk);
        end
        pkt_valid  = 1'b0;
        pkt_end    = 1'b1;
        pkt_crc_ok = crc;
        clr_eof    = clr_at_end;
        @(negedge clk);
        pkt_end = 1'b0;
        clr_eof = 1'b0;
    endtask

    task automatic pop_chk(input string req, input int data, input int eof, input int bv);
        chk_eq({req, " not empty"}, int'(rd_empty), 0);
        chk_eq({req, " data"}, int'(rd_data), data);
        chk_eq({req, " eof"}, int'(rd_eof), eof);
        chk_eq({req, " bv"}, int'(rd_bv), bv);
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic pulse_clr(input bit eof, input bit eot);
        clr_eof = eof;
        clr_eot = eot;
        @(negedge clk);
        clr_eof = 1'b0;
        clr_eot = 1'b0;
    endtask

    task automatic t_reset;
        chk_eq("R1 irq_eof", int'(irq_eof), 0);
        chk_eq("R1 irq_eot", int'(irq_eot), 0);
        chk_eq("R1 rd_empty", int'(rd_empty), 1);
        chk_eq("R1 hs_valid", int'(hs_valid), 0);
    endtask

    task automatic t_full_packet;
        send_pkt(MPS, 8'h10, 1'b1, 1'b0);
        chk_eq("R4 hs_valid", int'(hs_valid), 1);
        chk_eq("R4 ack", int'(hs_nak), 0);
        chk_eq("R4 irq_eof", int'(irq_eof), 1);
        chk_eq("R5 full size no eot", int'(irq_eot), 0);
        for (int i = 0; i < MPS; i++)
            pop_chk("R2 R3 full", 8'h10 + i, (i == MPS - 1) ? 1 : 0, 1);
        chk_eq("R3 drained", int'(rd_empty), 1);
        pulse_clr(1'b1, 1'b0);
        chk_eq("R12 clr_eof", int'(irq_eof), 0);
    endtask

    task automatic t_short_packet;
        send_pkt(2, 8'h20, 1'b1, 1'b0);
        chk_eq("R5 short sets eot", int'(irq_eot), 1);
        chk_eq("R4 short ack", int'(hs_valid && !hs_nak), 1);
        pop_chk("R2 short b0", 8'h20, 0, 1);
        pop_chk("R2 short b1", 8'h21, 1, 1);
    endtask

    task automatic t_nak_while_eot;
        send_pkt(3, 8'h30, 1'b1, 1'b0);
        chk_eq("R7 hs_valid", int'(hs_valid), 1);
        chk_eq("R7 nak", int'(hs_nak), 1);
        chk_eq("R7 nothing stored", int'(rd_empty), 1);
        chk_eq("R7 eot kept", int'(irq_eot), 1);
        pulse_clr(1'b1, 1'b0);
        send_pkt(0, 0, 1'b1, 1'b0);
        chk_eq("R7 zlp nak", int'(hs_nak), 1);
        chk_eq("R7 eof unchanged", int'(irq_eof), 0);
    endtask

    task automatic t_clear_and_zlp;
        clr_eot = 1'b1;
        @(negedge clk) clr_eot = 1'b0;
        chk_eq("R8 eot low next cycle", int'(irq_eot), 0);
        send_pkt(0, 0, 1'b1, 1'b0);
        chk_eq("R6 zlp ack", int'(hs_valid && !hs_nak), 1);
        chk_eq("R6 zlp eot", int'(irq_eot), 1);
        chk_eq("R8 accepted eof", int'(irq_eof), 1);
        pop_chk("R6 zlp entry", 0, 1, 0);
        chk_eq("R6 single entry", int'(rd_empty), 1);
        pulse_clr(1'b1, 1'b1);
    endtask

    task automatic t_bad_crc;
        send_pkt(3, 8'h50, 1'b0, 1'b0);
        chk_eq("R9 no handshake", int'(hs_valid), 0);
        chk_eq("R9 empty", int'(rd_empty), 1);
        chk_eq("R9 no eof", int'(irq_eof), 0);
        chk_eq("R9 no eot", int'(irq_eot), 0);
        send_pkt(MPS, 8'h60, 1'b1, 1'b0);
        for (int i = 0; i < MPS; i++)
            pop_chk("R9 retry stored", 8'h60 + i, (i == MPS - 1) ? 1 : 0, 1);
        chk_eq("R9 retry only", int'(rd_empty), 1);
        pulse_clr(1'b1, 1'b0);
    endtask

    task automatic t_oversize;
        send_pkt(MPS + 1, 8'h70, 1'b1, 1'b0);
        chk_eq("R11 no handshake", int'(hs_valid), 0);
        chk_eq("R11 empty", int'(rd_empty), 1);
        chk_eq("R11 no eof", int'(irq_eof), 0);
    endtask

    task automatic t_fill;
        for (int p = 0; p < DEPTH / MPS; p++) begin
            send_pkt(MPS, 8'h80 + p * MPS, 1'b1, 1'b0);
            chk_eq("R10 fill ack", int'(hs_valid && !hs_nak), 1);
        end
        send_pkt(1, 8'hF0, 1'b1, 1'b0);
        chk_eq("R10 full nak", int'(hs_valid && hs_nak), 1);
        chk_eq("R10 no eot", int'(irq_eot), 0);
        for (int i = 0; i < DEPTH; i++)
            pop_chk("R10 drain", 8'h80 + i, ((i % MPS) == MPS - 1) ? 1 : 0, 1);
        chk_eq("R10 drained", int'(rd_empty), 1);
        pulse_clr(1'b1, 1'b0);
        send_pkt(1, 8'hA5, 1'b1, 1'b0);
        chk_eq("R10 accepted after drain", int'(hs_valid && !hs_nak), 1);
        pop_chk("R10 after drain", 8'hA5, 1, 1);
        pulse_clr(1'b1, 1'b1);
    endtask

    task automatic t_clear_collision;
        send_pkt(MPS, 8'hB0, 1'b1, 1'b0);
        chk_eq("R12 eof set", int'(irq_eof), 1);
        send_pkt(MPS, 8'hC0, 1'b1, 1'b1);
        chk_eq("R12 set wins over clear", int'(irq_eof), 1);
        pulse_clr(1'b1, 1'b0);
        chk_eq("R12 cleared", int'(irq_eof), 0);
        for (int i = 0; i < 2 * MPS; i++) begin
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        chk_eq("R3 empty after pops", int'(rd_empty), 1);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: all R, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_packet();
        t_short_packet();
        t_nak_while_eot();
        t_clear_and_zlp();
        t_bad_crc();
        t_oversize();
        t_fill();
        t_clear_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule